// File: doc/BRIEF.md
# SPD Boot Mirror

At power-up, this block copies the whole 256-byte serial presence-detect EEPROM of a memory module into a local buffer. It reads the EEPROM over a two-wire serial bus. The bus clock is made by dividing the system clock by a fixed ratio. The default ratio of 256 turns a 24 MHz clock into 93.75 kHz, so each bit takes one SCL period and the bus stays below 100 kbit/s. Both lines are open-drain. The block only pulls a line low through an output enable, and it reads SDA back through an input.

The transfer starts by itself when reset is released. The block sets the EEPROM's word pointer to zero with a write frame. It then issues a repeated start and reads all bytes in one sequential burst. The lower half of the image holds the module type, the memory organisation and the timing data.

After the burst, any byte can be fetched through a synchronous read port with one cycle of latency. Until the copy is complete, that port returns zero. If the EEPROM fails to acknowledge, the transfer is abandoned with a stop condition and an error flag is raised.

Top module: `spd_mirror`

## Requirements
- R1: While reset is asserted and directly after it, done, error and rd_data are 0, and neither line is pulled low.
- R2: Every SCL low phase and every SCL high phase lasts CLK_DIV/2 system clocks. The default CLK_DIV is 256.
- R3: The bus sequence is: start, byte 0xA0, word address 0x00, repeated start, byte 0xA1, then sequential reads. The device address is 7'b1010000. The R/W bit sits in bit 0 and is set to 1 for a read. Each byte is sent MSB first.
- R4: SDA driven by the block changes while SCL is high only to form a start or a stop condition.
- R5: The block acknowledges each received byte with SDA low, except byte 255, which it NACKs with SDA high. It then issues a stop.
- R6: The byte received in position n of the burst is stored at buffer location n. Once done is set, rd_data shows that byte one cycle after rd_addr = n is presented.
- R7: A read presented while done is low returns 0x00 in the following cycle. This includes reads presented during the fill and in the cycle done rises.
- R8: If the EEPROM does not acknowledge any address byte, the block issues a stop and sets error. done stays low and no further SCL pulses follow.
- R9: done and error are never both set. Each stays set until reset. Once either is set, both lines are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; the transfer starts on release |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sampled SDA line level |
| rd_addr | input | AW | Buffer byte address |
| rd_data | output | 8 | Buffer byte, one cycle after rd_addr |
| done | output | 1 | Whole image copied |
| error | output | 1 | Transfer aborted on a missing acknowledge |

## Verification
The buffer read port and the fill engine can act in the same cycle. This happens both while bytes are being stored and at the edge where done rises. To provoke it, the bench holds rd_addr on the last location throughout the fill. At the first sample where done is high, it expects 0x00, because the read was presented while done was still low. At the next sample, it expects the final EEPROM byte. A scoreboard of expected bus events, compared against an EEPROM model, judges the framing and the NACK-abort paths at the same time.

// File: rtl/spd_mirror.sv
module spd_mirror #(
  parameter int CLK_DIV = 256,
  parameter int AW = 8,
  parameter logic [6:0] DEV_ID = 7'b1010000
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic          sda_in,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          done,
  output logic          error
);
  localparam int QDIV  = CLK_DIV / 4;
  localparam int QW    = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam int DEPTH = 1 << AW;

  typedef enum logic [2:0] {
    S_START, S_DEVW, S_WORD, S_RSTART, S_DEVR, S_READ, S_STOP, S_HALT
  } st_t;

  st_t           st;
  logic [QW-1:0] qcnt;
  logic [1:0]    ph;
  logic [3:0]    bc;
  logic [7:0]    shreg;
  logic [AW-1:0] waddr;
  logic          nack, fail;
  logic [7:0]    mem [DEPTH];
  logic [7:0]    tx_byte;
  logic          bit_val, is_start, is_stop, is_bit, last, qtick, buf_we;
  logic          frame_edge;

  assign qtick    = (qcnt == QW'(QDIV - 1)) && (st != S_HALT);
  assign last     = &waddr;
  assign is_start = (st == S_START) || (st == S_RSTART);
  assign is_stop  = (st == S_STOP);
  assign is_bit   = (st == S_DEVW) || (st == S_WORD) || (st == S_DEVR) || (st == S_READ);
  assign frame_edge = is_start || is_stop;
  assign buf_we   = qtick && (ph == 2'd3) && (st == S_READ) && (bc == 4'd8);

  always_comb begin
    case (st)
      S_DEVW:  tx_byte = {DEV_ID, 1'b0};
      S_DEVR:  tx_byte = {DEV_ID, 1'b1};
      default: tx_byte = 8'h00;
    endcase
    if (st == S_READ) bit_val = (bc == 4'd8) ? last : 1'b1;
    else              bit_val = (bc == 4'd8) ? 1'b1 : tx_byte[~bc[2:0]];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   qcnt <= '0;
    else if (qcnt == QW'(QDIV-1)) qcnt <= '0;
    else                          qcnt <= qcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_START; ph <= 2'd0; bc <= 4'd0; shreg <= 8'h00; waddr <= '0;
      nack <= 1'b0; fail <= 1'b0; scl_oe <= 1'b0; sda_oe <= 1'b0;
      done <= 1'b0; error <= 1'b0;
    end else if (qtick) begin
      ph <= ph + 2'd1;
      case (ph)
        2'd0: sda_oe <= is_stop ? 1'b1 : (is_start ? 1'b0 : !bit_val);
        2'd1: scl_oe <= 1'b0;
        2'd2: begin
          if (is_start) sda_oe <= 1'b1;
          if (is_stop)  sda_oe <= 1'b0;
          if (st == S_READ && bc != 4'd8) shreg <= {shreg[6:0], sda_in};
          if (is_bit && st != S_READ && bc == 4'd8) nack <= sda_in;
        end
        default: begin
          scl_oe <= !is_stop;
          case (st)
            S_START:  begin st <= S_DEVW; bc <= 4'd0; end
            S_RSTART: begin st <= S_DEVR; bc <= 4'd0; end
            S_DEVW, S_WORD, S_DEVR: begin
              if (bc != 4'd8) bc <= bc + 4'd1;
              else begin
                bc <= 4'd0;
                if (nack) begin fail <= 1'b1; st <= S_STOP; end
                else if (st == S_DEVW) st <= S_WORD;
                else if (st == S_WORD) st <= S_RSTART;
                else                   st <= S_READ;
              end
            end
            S_READ: begin
              if (bc != 4'd8) bc <= bc + 4'd1;
              else begin
                bc <= 4'd0;
                if (last) st <= S_STOP;
                else      waddr <= waddr + 1'b1;
              end
            end
            S_STOP: begin st <= S_HALT; done <= !fail; error <= fail; end
            default: st <= S_HALT;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk)
    if (buf_we) mem[waddr] <= shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rd_data <= 8'h00;
    else        rd_data <= done ? mem[rd_addr] : 8'h00;
endmodule

// File: rtl/spd_mirror_chk.sv
module spd_mirror_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       done,
  input logic       error,
  input logic [7:0] rd_data,
  input logic       frame_edge
);
  AST_SDA_EDGE_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && !$stable(sda_oe)) |-> frame_edge); // R4
  AST_ZERO_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (rd_data == 8'h00)); // R7
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error)); // R9
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> (error && !scl_oe)); // R8
  AST_BUS_FREE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> (!scl_oe && !sda_oe)); // R9
endmodule

bind spd_mirror spd_mirror_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .done(done), .error(error), .rd_data(rd_data), .frame_edge(frame_edge)
);

// File: tb/spd_mirror_test.sv
`timescale 1ns/1ps
module spd_mirror_test;
  localparam int CLKD = 16;
  localparam int EV_START = 256, EV_STOP = 512, EV_ACK = 768;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] rd_addr = 8'h00;
  logic scl_oe, sda_oe, done, error;
  logic [7:0] rd_data;
  logic slv_low = 1'b0;
  wire scl_line = !scl_oe;
  wire sda_line = !(sda_oe | slv_low);

  always #2.5 clk = ~clk;

  spd_mirror #(.CLK_DIV(CLKD)) uut (
    .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_line),
    .rd_addr(rd_addr), .rd_data(rd_data), .done(done), .error(error));

  int n_chk = 0, n_bad = 0;
  int exp_q[$];
  int nack_sel = 0;
  int scl_falls = 0;

  function automatic logic [7:0] spd_val(int i);
    return 8'((i * 37 + 11) ^ (i >> 2));
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic see_ev(int e);
    if (exp_q.size() == 0) check(1'b0, "R3 unexpected bus event", e, -1);
    else begin
      int x;
      x = exp_q.pop_front();
      check(x == e, "R3 bus event", e, x);
    end
  endtask

  task automatic push_frame(int sel);
    exp_q.delete();
    exp_q.push_back(EV_START); exp_q.push_back(8'hA0);
    if (sel != 1) exp_q.push_back(8'h00);
    if (sel == 0 || sel == 3) begin exp_q.push_back(EV_START); exp_q.push_back(8'hA1); end
    if (sel == 0) begin
      for (int i = 0; i < 255; i++) exp_q.push_back(EV_ACK);
      exp_q.push_back(EV_ACK | 1);
    end
    exp_q.push_back(EV_STOP);
  endtask

  // EEPROM model and bus monitor
  logic ps = 1'b1, pd = 1'b1, s, d, mack, nak;
  logic [7:0] sh, tb;
  int md = 0, bn = 0, fb = 0, ptr = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      md = 0; bn = 0; fb = 0; ptr = 0; ps = 1'b1; pd = 1'b1; nak = 1'b0; slv_low <= 1'b0;
    end else begin
      s = scl_line; d = sda_line;
      if (ps && s && pd && !d) begin see_ev(EV_START); md = 1; bn = 0; fb = 0; slv_low <= 1'b0; end
      else if (ps && s && !pd && d) begin see_ev(EV_STOP); md = 0; slv_low <= 1'b0; end
      else if (!ps && s) begin
        if (md == 1) begin if (bn < 8) sh = {sh[6:0], d}; bn++; end
        else if (md == 2) begin
          if (bn == 8) begin mack = d; see_ev(EV_ACK | int'(d)); end
          bn++;
        end
      end else if (ps && !s) begin
        scl_falls++;
        if (md == 1) begin
          if (bn == 8) begin
            see_ev(int'(sh));
            nak = (nack_sel == 1 && fb == 0 && !sh[0]) || (nack_sel == 2 && fb == 1) ||
                  (nack_sel == 3 && fb == 0 && sh[0]);
            slv_low <= !nak;
          end else if (bn == 9) begin
            slv_low <= 1'b0; bn = 0;
            if (nak) md = 0;
            else if (fb == 0 && sh[0]) begin md = 2; tb = spd_val(ptr); slv_low <= !tb[7]; end
            else begin if (fb == 1) ptr = int'(sh); fb++; end
          end
        end else if (md == 2) begin
          tb = spd_val(ptr);
          if (bn < 8) slv_low <= !tb[7 - bn];
          else if (bn == 8) slv_low <= 1'b0;
          else if (!mack) begin ptr = (ptr + 1) % 256; bn = 0; tb = spd_val(ptr); slv_low <= !tb[7]; end
          else begin md = 0; slv_low <= 1'b0; end
        end
      end
      ps = s; pd = d;
    end
  end

  // R2: SCL phase length monitor
  logic pscl = 1'b1;
  int run_len = 0, n_int = 0;
  bit seen_fall = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) begin pscl = 1'b1; run_len = 0; seen_fall = 1'b0; end
    else begin
      if (scl_line != pscl) begin
        if (seen_fall && n_int < 40) begin
          check(run_len == CLKD / 2, "R2 scl phase length", run_len, CLKD / 2);
          n_int++;
        end
        if (!scl_line) seen_fall = 1'b1;
        run_len = 1;
      end else run_len++;
      pscl = scl_line;
    end
  end

  task automatic wait_end();
    int n = 0;
    while (!(done || error) && n < 60000) begin @(negedge clk); n++; end
    check(done || error, "R8/R9 transfer end", n, 60000);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int f0;
    repeat (4) @(negedge clk);
    check({done, error, scl_oe, sda_oe} == 4'b0, "R1 reset outputs", {done, error, scl_oe, sda_oe}, 0);
    check(rd_data == 8'h00, "R1 reset rd_data", rd_data, 0);
    push_frame(0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!scl_oe && !sda_oe, "R1 lines released after reset", {scl_oe, sda_oe}, 0);
    repeat (20000) @(negedge clk);
    rd_addr = 8'd3; @(negedge clk);
    check(rd_data == 8'h00, "R7 read during fill", rd_data, 0);
    rd_addr = 8'd0; @(negedge clk);
    check(rd_data == 8'h00, "R7 read during fill", rd_data, 0);
    rd_addr = 8'd255;
    wait_end();
    check(rd_data == 8'h00, "R7 read in cycle done rises", rd_data, 0);
    @(negedge clk);
    check(rd_data == spd_val(255), "R6 last byte after done", rd_data, spd_val(255));
    check(done && !error, "R9 done without error", {done, error}, 2);
    check(exp_q.size() == 0, "R5 frame complete with nack and stop", exp_q.size(), 0);
    for (int i = 0; i < 256; i++) begin
      rd_addr = 8'(i); @(negedge clk);
      check(rd_data == spd_val(i), "R6 buffer byte", rd_data, spd_val(i));
    end
    f0 = scl_falls;
    repeat (300) @(negedge clk);
    check(done && !error && !scl_oe && !sda_oe, "R9 sticky and released", {done, error, scl_oe, sda_oe}, 8);
    check(scl_falls == f0, "R9 no clocks after done", scl_falls - f0, 0);

    for (int sel = 1; sel <= 3; sel++) begin
      rst_n = 1'b0; nack_sel = sel;
      repeat (3) @(negedge clk);
      push_frame(sel);
      rst_n = 1'b1;
      wait_end();
      check(error && !done, "R8 error set, done low", {done, error}, 1);
      f0 = scl_falls;
      rd_addr = 8'd1;
      repeat (500) @(negedge clk);
      check(scl_falls == f0, "R8 no clocks after abort", scl_falls - f0, 0);
      check(exp_q.size() == 0, "R8 stop issued after nack", exp_q.size(), 0);
      check(rd_data == 8'h00, "R7 read after abort", rd_data, 0);
      check(error && !scl_oe && !sda_oe, "R9 error sticky, lines released", {error, scl_oe, sda_oe}, 4);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule